// File: doc/BRIEF.md
# Latched-Address Memory Cycle Sequencer

This block sits between a simple host request port and an asynchronous byte-wide static memory. That memory captures its address internally when its active-low chip enable falls. The host raises a request for one clock together with a direction flag, an address and write data. The sequencer then runs one access on the memory pins: it presents the address just before chip enable falls, removes the address after a short hold, and keeps chip enable low for the required access window. For reads it captures the returned byte, and for writes it pulses the write strobe while it drives the data lines. It then keeps chip enable high for a recovery interval, and a one-clock completion pulse ends the access.

Every timing limit is given as a nanosecond parameter together with the system clock period. The block rounds each limit up to whole clocks, so the same RTL serves both a fast and a slow memory grade. A write request can also ask to keep the write strobe asserted after it finishes. Consecutive writes then share one continuous low write strobe, and each of them is ended by chip enable rising.

Top module: `latched_mem_seq`

## Requirements
- R1: While reset is held and in the cycle after it, chip enable, write strobe and output enable are all high (inactive), the data drive enable and the done pulse are low, and the memory address bus is zero.
- R2: Each access keeps chip enable low for exactly ELOW = AHOLD + ACC + 1 consecutive clocks. Here AHOLD = max(1, ceil(t_ahold/clk)), ELOW_REQ = max(ceil(t_elow/clk), ceil(t_access/clk)), and ACC = max(ELOW_REQ - AHOLD - 1, ceil(t_wpulse/clk) - 1, ceil(t_dsetup/clk) - 1, 1). Chip enable falls in the second clock after the request is accepted.
- R3: The memory address bus carries the accepted address for exactly 1 + AHOLD clocks: one clock with chip enable still high, then the first AHOLD clocks with it low. At all other times the bus is zero, so the address is stable across the falling edge of chip enable.
- R4: A read keeps the write strobe high and drives output enable low only during the last ACC + 1 clocks that chip enable is low. The host read data takes the memory input sampled on the last of those clocks and keeps that value until the next read completes. Output enable and the write strobe are never low together.
- R5: A write holds output enable high. Outside a burst it drives the write strobe low for the last ACC + 1 clocks that chip enable is low, so the strobe rises together with chip enable. The data drive enable is high, with the write data on the data-out bus, from the first clock of the strobe until DHOLD = max(1, ceil(t_dhold/clk)) clocks after chip enable rises. At all other times the data-out bus is zero.
- R6: After each access chip enable stays high for REC = max(ceil(t_ehigh/clk), ceil(t_cycle/clk) - ELOW, DHOLD, 1) clocks. The done output is high for exactly one clock, the last of those, and a new request can be accepted from the next clock on.
- R7: A request raised while an access is in progress is ignored: it starts no access, and neither the memory contents nor the memory pins change because of it.
- R8: A write with the burst flag set leaves the write strobe low after chip enable rises, and the strobe stays low while the block is idle. If the next accepted request is a write, the strobe stays low through that whole access. If it is a read, the strobe goes high in the first clock after acceptance. A write without the burst flag releases the strobe when its chip enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, sampled only while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_burst | input | 1 | Keep the write strobe low after this write |
| host_addr | input | ADDR_W (11) | Access address |
| host_wdata | input | DATA_W (8) | Write data |
| host_done | output | 1 | One-clock completion pulse |
| host_rdata | output | DATA_W (8) | Last captured read byte |
| mem_addr | output | ADDR_W (11) | Memory address, driven only around chip enable falling |
| mem_e_n | output | 1 | Chip enable, active low |
| mem_w_n | output | 1 | Write strobe, active low |
| mem_g_n | output | 1 | Output enable, active low |
| mem_dout | output | DATA_W (8) | Data toward memory |
| mem_dout_oe | output | 1 | Drive enable for mem_dout |
| mem_din | input | DATA_W (8) | Data from memory |

## Verification
The bench builds the block with its default fast-grade parameters: a 10 ns clock, 30 ns address hold, 120 ns low time and access, 50 ns recovery, 170 ns cycle and 10 ns data hold. These give phases of 3, 11 and 5 clocks, with chip enable low for 15 clocks. Because the write-pulse term sets the access length here, the read-access and cycle terms are exercised only as limits that are already met. The data-hold term rounds to one clock, so the drive-enable tail is a single clock. Every clock of every access is compared with the expected pin levels. A bench memory model, which latches on the chip-enable edge, gives the data to check read-back against a shadow copy.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR_SETUP,
        PH_E_LOW_HOLD,
        PH_ACCESS,
        PH_CAPTURE,
        PH_COMMIT,
        PH_E_HIGH_RECOVER
    } phase_e;

    typedef struct packed {
        logic e_n;
        logic w_n;
        logic g_n;
        logic oe;
        logic addr_en;
        logic done;
        logic cap;
    } strobe_t;

    function automatic int ceil_cyc(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mcs_phase_ctrl.sv
module mcs_phase_ctrl
    import mcs_pkg::*;
#(
    parameter int AHOLD_C = 3,
    parameter int ACC_C   = 11,
    parameter int REC_C   = 5,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_write,
    output phase_e           phase,
    output logic [CNT_W-1:0] remain
);

    phase_e           phase_nx;
    logic [CNT_W-1:0] remain_nx;
    logic             expired;

    assign expired = (remain == '0);

    always_comb begin
        phase_nx  = phase;
        remain_nx = expired ? '0 : remain - 1'b1;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    phase_nx  = PH_ADDR_SETUP;
                    remain_nx = '0;
                end
            end
            PH_ADDR_SETUP: begin
                phase_nx  = PH_E_LOW_HOLD;
                remain_nx = CNT_W'(AHOLD_C - 1);
            end
            PH_E_LOW_HOLD: begin
                if (expired) begin
                    phase_nx  = PH_ACCESS;
                    remain_nx = CNT_W'(ACC_C - 1);
                end
            end
            PH_ACCESS: begin
                if (expired) begin
                    phase_nx  = is_write ? PH_COMMIT : PH_CAPTURE;
                    remain_nx = '0;
                end
            end
            PH_CAPTURE, PH_COMMIT: begin
                phase_nx  = PH_E_HIGH_RECOVER;
                remain_nx = CNT_W'(REC_C - 1);
            end
            PH_E_HIGH_RECOVER: begin
                if (expired) begin
                    phase_nx  = PH_IDLE;
                    remain_nx = '0;
                end
            end
            default: begin
                phase_nx  = PH_IDLE;
                remain_nx = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else begin
            phase  <= phase_nx;
            remain <= remain_nx;
        end
    end

endmodule

// File: rtl/mcs_strobe_dec.sv
module mcs_strobe_dec
    import mcs_pkg::*;
#(
    parameter int REC_C   = 5,
    parameter int DHOLD_C = 1,
    parameter int CNT_W   = 4
) (
    input  phase_e           phase,
    input  logic [CNT_W-1:0] remain,
    input  logic             we,
    input  logic             w_hold,
    output strobe_t          strb
);

    localparam int HOLD_FLOOR = REC_C - DHOLD_C;

    logic in_low;
    logic in_drive;
    logic in_tail;

    assign in_low   = (phase == PH_E_LOW_HOLD) || (phase == PH_ACCESS)
                   || (phase == PH_CAPTURE)    || (phase == PH_COMMIT);
    assign in_drive = (phase == PH_ACCESS) || (phase == PH_COMMIT);
    assign in_tail  = (phase == PH_E_HIGH_RECOVER) && (int'(remain) >= HOLD_FLOOR);

    always_comb begin
        strb.e_n     = !in_low;
        strb.addr_en = (phase == PH_ADDR_SETUP) || (phase == PH_E_LOW_HOLD);
        strb.g_n     = !(!we && ((phase == PH_ACCESS) || (phase == PH_CAPTURE)));
        strb.w_n     = !(w_hold || (we && in_drive));
        strb.oe      = we && (in_drive || in_tail);
        strb.done    = (phase == PH_E_HIGH_RECOVER) && (remain == '0);
        strb.cap     = (phase == PH_CAPTURE);
    end

endmodule

// File: rtl/mcs_xfer_regs.sv
module mcs_xfer_regs
    import mcs_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_we,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              commit_end,
    input  strobe_t           strb,
    input  logic [DATA_W-1:0] mem_din,
    output logic              we_q,
    output logic              w_hold,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic [DATA_W-1:0] host_rdata
);

    logic              burst_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q       <= 1'b0;
            burst_q    <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            w_hold     <= 1'b0;
            host_rdata <= '0;
        end else begin
            if (accept) begin
                we_q    <= req_we;
                burst_q <= req_burst;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                if (!req_we) begin
                    w_hold <= 1'b0;
                end
            end else if (commit_end) begin
                w_hold <= burst_q;
            end
            if (strb.cap) begin
                host_rdata <= mem_din;
            end
        end
    end

    assign mem_addr = strb.addr_en ? addr_q  : '0;
    assign mem_dout = strb.oe      ? wdata_q : '0;

endmodule

// File: rtl/latched_mem_seq.sv
module latched_mem_seq
    import mcs_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 10,
    parameter int T_AHOLD_NS  = 30,
    parameter int T_ELOW_NS   = 120,
    parameter int T_ACCESS_NS = 120,
    parameter int T_EHIGH_NS  = 50,
    parameter int T_CYCLE_NS  = 170,
    parameter int T_WPULSE_NS = 120,
    parameter int T_DSETUP_NS = 50,
    parameter int T_DHOLD_NS  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_burst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_e_n,
    output logic              mem_w_n,
    output logic              mem_g_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_oe,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int AHOLD_C  = max2(1, ceil_cyc(T_AHOLD_NS, CLK_NS));
    localparam int ELOW_REQ = max2(ceil_cyc(T_ELOW_NS, CLK_NS), ceil_cyc(T_ACCESS_NS, CLK_NS));
    localparam int ACC_C    = max2(max2(ELOW_REQ - AHOLD_C - 1, ceil_cyc(T_WPULSE_NS, CLK_NS) - 1),
                                   max2(ceil_cyc(T_DSETUP_NS, CLK_NS) - 1, 1));
    localparam int ELOW_C   = AHOLD_C + ACC_C + 1;
    localparam int DHOLD_C  = max2(1, ceil_cyc(T_DHOLD_NS, CLK_NS));
    localparam int REC_C    = max2(max2(ceil_cyc(T_EHIGH_NS, CLK_NS), ceil_cyc(T_CYCLE_NS, CLK_NS) - ELOW_C),
                                   max2(DHOLD_C, 1));
    localparam int MAX_C    = max2(max2(AHOLD_C, ACC_C), REC_C);
    localparam int CNT_W    = $clog2(MAX_C + 1);

    phase_e           phase;
    logic [CNT_W-1:0] remain;
    strobe_t          strb;
    logic             accept;
    logic             we_q;
    logic             w_hold;

    assign accept = (phase == PH_IDLE) && host_req;

    mcs_phase_ctrl #(
        .AHOLD_C (AHOLD_C),
        .ACC_C   (ACC_C),
        .REC_C   (REC_C),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .is_write (we_q),
        .phase    (phase),
        .remain   (remain)
    );

    mcs_strobe_dec #(
        .REC_C   (REC_C),
        .DHOLD_C (DHOLD_C),
        .CNT_W   (CNT_W)
    ) u_dec (
        .phase  (phase),
        .remain (remain),
        .we     (we_q),
        .w_hold (w_hold),
        .strb   (strb)
    );

    mcs_xfer_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_we     (host_we),
        .req_burst  (host_burst),
        .req_addr   (host_addr),
        .req_wdata  (host_wdata),
        .commit_end (phase == PH_COMMIT),
        .strb       (strb),
        .mem_din    (mem_din),
        .we_q       (we_q),
        .w_hold     (w_hold),
        .mem_addr   (mem_addr),
        .mem_dout   (mem_dout),
        .host_rdata (host_rdata)
    );

    assign mem_e_n     = strb.e_n;
    assign mem_w_n     = strb.w_n;
    assign mem_g_n     = strb.g_n;
    assign mem_dout_oe = strb.oe;
    assign host_done   = strb.done;

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
    parameter int ELOW_C = 15,
    parameter int REC_C  = 5,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              e_n,
    input logic              w_n,
    input logic              g_n,
    input logic              oe,
    input logic              done,
    input logic [ADDR_W-1:0] addr
);

    logic [15:0] low_run;
    logic [15:0] high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= 16'hFFFF;
        end else begin
            low_run  <= e_n ? '0 : ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1);
            high_run <= !e_n ? '0 : ((high_run == 16'hFFFF) ? high_run : high_run + 1'b1);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (e_n && w_n && g_n && !oe && !done && addr == '0));

    assert_elow_len_R2: assert property (@(posedge clk) disable iff (rst)
        (!e_n && $past(!e_n) && e_n == 1'b0) |-> (int'(low_run) < ELOW_C));

    assert_elow_min_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(e_n) |-> (int'(low_run) >= ELOW_C));

    assert_addr_stable_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(e_n) |-> (addr == $past(addr)));

    assert_no_g_w_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(!g_n && !w_n));

    assert_drive_not_while_g_R5: assert property (@(posedge clk) disable iff (rst)
        oe |-> g_n);

    assert_drive_starts_w_low_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> !w_n);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_e_high_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> e_n);

    assert_recover_min_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(e_n) |-> (int'(high_run) >= REC_C));

endmodule

bind latched_mem_seq mcs_checker #(
    .ELOW_C (ELOW_C),
    .REC_C  (REC_C),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .e_n  (mem_e_n),
    .w_n  (mem_w_n),
    .g_n  (mem_g_n),
    .oe   (mem_dout_oe),
    .done (host_done),
    .addr (mem_addr)
);

// File: tb/tb_latched_mem_seq.sv
module tb_latched_mem_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 8;

    // Expected phase lengths derived from R2, R5, R6 with the default parameters
    function automatic int cdiv(input int t, input int c);
        return (t + c - 1) / c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int AHOLD = mx(1, cdiv(30, CLK_PERIOD));
    localparam int EREQ  = mx(cdiv(120, CLK_PERIOD), cdiv(120, CLK_PERIOD));
    localparam int ACC   = mx(mx(EREQ - AHOLD - 1, cdiv(120, CLK_PERIOD) - 1), mx(cdiv(50, CLK_PERIOD) - 1, 1));
    localparam int ELOW  = AHOLD + ACC + 1;
    localparam int DHOLD = mx(1, cdiv(10, CLK_PERIOD));
    localparam int REC   = mx(mx(cdiv(50, CLK_PERIOD), cdiv(170, CLK_PERIOD) - ELOW), mx(DHOLD, 1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic          host_burst = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_done;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_e_n, mem_w_n, mem_g_n;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_oe;
    logic [DW-1:0] mem_din;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit w_held = 1'b0;
    logic [DW-1:0] shadow [0:(1<<AW)-1];
    logic [DW-1:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_mem_seq dut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_burst(host_burst),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_e_n(mem_e_n), .mem_w_n(mem_w_n), .mem_g_n(mem_g_n),
        .mem_dout(mem_dout), .mem_dout_oe(mem_dout_oe), .mem_din(mem_din)
    );

    // Memory model: latches address when E falls, stores on E rising while W low
    logic [DW-1:0] model_mem [0:(1<<AW)-1];
    logic [AW-1:0] lat = '0;
    logic          prev_e = 1'b1;
    logic          prev_w = 1'b1;
    logic          prev_oe = 1'b0;
    logic [DW-1:0] prev_dout = '0;

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < (1<<AW); i++) model_mem[i] = '0;
            prev_e = 1'b1;
            prev_w = 1'b1;
        end else begin
            if (prev_e && !mem_e_n) lat = mem_addr;
            if (!prev_e && mem_e_n && !prev_w) model_mem[lat] = prev_oe ? prev_dout : 8'h00;
            prev_e    = mem_e_n;
            prev_w    = mem_w_n;
            prev_oe   = mem_dout_oe;
            prev_dout = mem_dout;
        end
    end

    assign mem_din = (!mem_e_n && !mem_g_n) ? model_mem[lat] : 8'hC3;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_access(input bit we, input bit burst, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input bit poke_busy);
        int bad_e, bad_a, bad_w, bad_g, bad_oe, bad_d, bad_done;
        bad_e = 0; bad_a = 0; bad_w = 0; bad_g = 0; bad_oe = 0; bad_d = 0; bad_done = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_burst = burst; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_addr = ~a; host_wdata = ~d;
        for (int idx = 0; idx <= ELOW + REC; idx++) begin
            bit xe, xa, xw, xg, xo, xd;
            if (idx > 0) @(negedge clk);
            if (poke_busy && idx == 6) begin host_req = 1'b1; host_we = 1'b1; end
            if (poke_busy && idx == 7) begin host_req = 1'b0; end
            xe = (idx >= 1 && idx <= ELOW);
            xa = (idx <= AHOLD);
            xw = we && ((w_held && idx <= ELOW) || (idx > AHOLD && idx <= ELOW) || (burst && idx > ELOW));
            xg = !we && idx > AHOLD && idx <= ELOW;
            xo = we && idx > AHOLD && idx <= ELOW + DHOLD;
            xd = (idx == ELOW + REC);
            if (mem_e_n != !xe) bad_e++;
            if (mem_addr != (xa ? a : '0)) bad_a++;
            if (mem_w_n != !xw) bad_w++;
            if (mem_g_n != !xg) bad_g++;
            if (mem_dout_oe != xo) bad_oe++;
            if (mem_dout != (xo ? d : '0)) bad_d++;
            if (host_done != xd) bad_done++;
        end
        host_we = 1'b0; host_burst = 1'b0;
        chk(bad_e == 0,    "R2 chip enable low window", bad_e, 0);
        chk(bad_a == 0,    "R3 address window", bad_a, 0);
        chk(bad_w == 0,    "R5/R8 write strobe pattern", bad_w, 0);
        chk(bad_g == 0,    "R4 output enable pattern", bad_g, 0);
        chk(bad_oe == 0,   "R5 drive enable window", bad_oe, 0);
        chk(bad_d == 0,    "R5 write data on bus", bad_d, 0);
        chk(bad_done == 0, "R6 done pulse position", bad_done, 0);
        if (!we) begin
            chk(host_rdata == shadow[a], "R4 read data", host_rdata, shadow[a]);
            last_rd = host_rdata;
        end else begin
            shadow[a] = d;
            chk(host_rdata == last_rd, "R4 read data held across write", host_rdata, last_rd);
        end
        w_held = we ? burst : 1'b0;
    endtask

    task automatic idle_probe(input int n, input bit exp_w_low, input string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!mem_e_n || mem_w_n == exp_w_low || mem_dout_oe || host_done) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state while reset held
        chk(mem_e_n && mem_w_n && mem_g_n, "R1 strobes inactive in reset", {mem_e_n, mem_w_n, mem_g_n}, 7);
        chk(!mem_dout_oe && !host_done, "R1 drive/done low in reset", {mem_dout_oe, host_done}, 0);
        chk(mem_addr == '0, "R1 address zero in reset", mem_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_e_n && mem_w_n && mem_g_n && host_rdata == '0, "R1 state after reset", host_rdata, 0);

        // Directed: basic write/read, both address extremes
        run_access(1'b1, 1'b0, 11'h123, 8'h5A, 1'b0);
        run_access(1'b0, 1'b0, 11'h123, 8'h00, 1'b0);
        run_access(1'b1, 1'b0, 11'h7FF, 8'hFF, 1'b0);
        run_access(1'b1, 1'b0, 11'h000, 8'h81, 1'b0);
        run_access(1'b0, 1'b0, 11'h7FF, 8'h00, 1'b0);
        run_access(1'b0, 1'b0, 11'h000, 8'h00, 1'b0);

        // R7: request during a busy access is ignored
        run_access(1'b1, 1'b0, 11'h055, 8'h3C, 1'b1);
        idle_probe(6, 1'b0, "R7 no access started by busy request");
        run_access(1'b0, 1'b0, ~11'h055, 8'h00, 1'b0);
        run_access(1'b0, 1'b0, 11'h055, 8'h00, 1'b0);

        // R8: burst writes, strobe held low through idle
        run_access(1'b1, 1'b1, 11'h200, 8'h11, 1'b0);
        idle_probe(3, 1'b1, "R8 strobe held low while idle in burst");
        run_access(1'b1, 1'b1, 11'h201, 8'h22, 1'b0);
        run_access(1'b1, 1'b0, 11'h202, 8'h33, 1'b0);
        idle_probe(3, 1'b0, "R8 strobe released after final write");
        run_access(1'b0, 1'b0, 11'h200, 8'h00, 1'b0);
        run_access(1'b0, 1'b0, 11'h201, 8'h00, 1'b0);
        run_access(1'b0, 1'b0, 11'h202, 8'h00, 1'b0);
        // R8: burst write followed directly by a read
        run_access(1'b1, 1'b1, 11'h3A0, 8'hE7, 1'b0);
        run_access(1'b0, 1'b0, 11'h3A0, 8'h00, 1'b0);

        // Random mix
        for (int t = 0; t < 40; t++) begin
            bit rw, bu;
            rw = ($urandom % 2) == 1;
            bu = rw && (($urandom % 3) == 0);
            run_access(rw, bu, AW'($urandom % (1<<AW)), DW'($urandom), 1'b0);
            repeat ($urandom % 3) @(negedge clk);
        end
        run_access(1'b1, 1'b0, 11'h444, 8'h99, 1'b0);
        run_access(1'b0, 1'b0, 11'h444, 8'h00, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule